// File: doc/BRIEF.md
# SPI Master Byte Engine

This block is the master side of a serial peripheral link that moves one byte per transfer. A host loads a transmit byte and pulses a start strobe. The engine then drives a serial clock and shifts the byte out on the master-out line. In the same transfer it captures one byte from the master-in line, so each sent bit has a received bit taken alongside it. When the transfer ends it raises a one-cycle done pulse, presents the received byte, and can hold an interrupt request until the next transfer begins.

The clock polarity, the clock phase and the bit order are chosen at run time. They are captured when a transfer is accepted and stay fixed until it ends. The serial clock runs only during a transfer and otherwise rests at the level the polarity selects. The serial clock half-period is a build-time count of system clocks.

The active-low slave select is not tied to the transfer. It follows a host request bit, so the host asserts it before the start strobe and releases it after done. The engine refuses to start while slave select is released.

Top module: `spi_byte_master`

## Requirements
- R1: Each accepted transfer moves exactly 8 bits in each direction and produces exactly 16 serial clock edges, after which the serial clock is back at its rest level.
- R2: With `cpol`=0 the serial clock rests low, and with `cpol`=1 it rests high, whenever no transfer is in progress.
- R3: With `cpha`=0 the first data bit is on `mosi` before the first serial clock edge. `miso` is sampled on the 1st, 3rd, … 15th edges, and `mosi` moves to the next bit on the 2nd, 4th, … 14th edges.
- R4: With `cpha`=1 `mosi` presents each bit from the first edge of that bit, so its bit k is valid from edge 2k+1. `miso` is sampled on the 2nd, 4th, … 16th edges.
- R5: With `lsb_first`=1, bit 0 is sent first and the first received bit lands in bit 0. With `lsb_first`=0, bit 7 is sent first and the first received bit lands in bit 7.
- R6: `ss_n` equals the inverse of `sel_req` one system clock later. A start strobe seen while `ss_n` is high is ignored, and `busy` stays low.
- R7: A start strobe that arrives while `busy` is high is ignored. The running transfer keeps its transmit byte and its timing.
- R8: `busy` rises in the cycle after an accepted start. The first serial clock edge comes HALF_DIV+1 system clocks after that start. Later edges follow every HALF_DIV system clocks, and HALF_DIV is at least 1.
- R9: `done` is high for exactly one system clock, in the same cycle that `busy` falls. `rx_byte` changes only in a cycle where `done` is high and holds until the next completion.
- R10: A completion sets an interrupt pending flag. `irq` shows that flag while `irq_en` is 1 and is low while `irq_en` is 0. The flag clears when the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpol | input | 1 | Serial clock rest level (0 low, 1 high) |
| cpha | input | 1 | Sampling edge select (0 first edge of bit, 1 second edge) |
| lsb_first | input | 1 | Bit order (1 least significant bit first) |
| irq_en | input | 1 | Lets the pending completion flag reach `irq` |
| sel_req | input | 1 | Host request bit for slave select (1 asserts `ss_n` low) |
| start | input | 1 | Start strobe, sampled on the rising system clock edge |
| tx_byte | input | 8 | Byte to send, taken with an accepted start |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| ss_n | output | 1 | Active-low slave select |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_byte | output | 8 | Byte received by the last completed transfer |
| irq | output | 1 | Interrupt request |

## Verification
Two cases are hard to reach from the ports. One is a start strobe that lands in the middle of a running transfer. The other is the requirement that each phase setting changes `mosi` and samples `miso` only on its own edges. The bench reaches both with a behavioural slave that counts serial clock edges independently, captures `mosi` on the edges the phase names and moves `miso` on the others. Any edge misplaced by the design therefore corrupts a byte in one of the two directions. A second start carrying a different byte is injected about ten cycles into a transfer; the bench then checks that the slave still captured the original byte and that the completion cycle did not move.

// File: rtl/spi_pkg.sv
package spi_pkg;

  localparam int unsigned SPI_BITS  = 8;
  localparam int unsigned SPI_EDGES = 2 * SPI_BITS;
  localparam int unsigned EDGE_W    = $clog2(SPI_EDGES);

  typedef logic [SPI_BITS-1:0] spi_word_t;
  typedef logic [EDGE_W-1:0]   spi_edge_t;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lsb_first;
  } spi_mode_t;

  // bit currently presented on the output line
  function automatic logic tx_bit(spi_word_t sr, logic lsb);
    return lsb ? sr[0] : sr[SPI_BITS-1];
  endfunction

  // move the transmit register on to the next bit
  function automatic spi_word_t tx_adv(spi_word_t sr, logic lsb);
    return lsb ? {1'b0, sr[SPI_BITS-1:1]} : {sr[SPI_BITS-2:0], 1'b0};
  endfunction

  // insert a received bit; after SPI_BITS pushes the first bit sits at
  // bit 0 (lsb first) or at the top bit (msb first)
  function automatic spi_word_t rx_push(spi_word_t sr, logic b, logic lsb);
    return lsb ? {b, sr[SPI_BITS-1:1]} : {sr[SPI_BITS-2:0], b};
  endfunction

  // edge index counts from 0; even indices are leading edges
  function automatic logic is_sample_edge(spi_edge_t idx, logic cpha);
    return idx[0] == cpha;
  endfunction

  function automatic logic is_shift_edge(spi_edge_t idx, logic cpha);
    logic other;
    other = (idx[0] != cpha);
    if (cpha) return other && (idx != '0);
    else      return other && (idx != spi_edge_t'(SPI_EDGES - 1));
  endfunction

  function automatic logic is_last_edge(spi_edge_t idx);
    return idx == spi_edge_t'(SPI_EDGES - 1);
  endfunction

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int unsigned HALF_DIV = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = $clog2(HALF_DIV + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  initial begin
    if (HALF_DIV < 1) $display("spi_half_timer: HALF_DIV must be at least 1");
  end
endmodule

// File: rtl/spi_edge_seq.sv
module spi_edge_seq
  import spi_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic tick,
  input  logic cpha,
  output logic run,
  output logic busy,
  output logic phase,
  output logic sample_stb,
  output logic shift_stb,
  output logic fin_stb
);
  typedef enum logic [1:0] {SQ_IDLE, SQ_SETUP, SQ_RUN} sq_state_t;

  sq_state_t state;
  spi_edge_t idx;

  assign run        = (state == SQ_RUN);
  assign busy       = (state != SQ_IDLE);
  assign sample_stb = tick && is_sample_edge(idx, cpha);
  assign shift_stb  = tick && is_shift_edge(idx, cpha);
  assign fin_stb    = tick && is_last_edge(idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      idx   <= '0;
      phase <= 1'b0;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          if (accept) state <= SQ_SETUP;
          idx   <= '0;
          phase <= 1'b0;
        end
        SQ_SETUP: state <= SQ_RUN;
        SQ_RUN: begin
          if (tick) begin
            phase <= ~phase;
            idx   <= idx + 1'b1;
            if (is_last_edge(idx)) state <= SQ_IDLE;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_shift_path.sv
module spi_shift_path
  import spi_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  spi_word_t tx_byte,
  input  logic      lsb,
  input  logic      miso,
  input  logic      sample_stb,
  input  logic      shift_stb,
  input  logic      fin_stb,
  output logic      mosi,
  output spi_word_t rx_byte
);
  spi_word_t tx_sr;
  spi_word_t rx_sr;
  spi_word_t rx_nxt;

  assign mosi   = tx_bit(tx_sr, lsb);
  assign rx_nxt = sample_stb ? rx_push(rx_sr, miso, lsb) : rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr   <= '0;
      rx_sr   <= '0;
      rx_byte <= '0;
    end else begin
      if (load) begin
        tx_sr <= tx_byte;
        rx_sr <= '0;
      end else begin
        if (shift_stb) tx_sr <= tx_adv(tx_sr, lsb);
        rx_sr <= rx_nxt;
      end
      if (fin_stb) rx_byte <= rx_nxt;
    end
  end
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_pkg::*;
#(
  parameter int unsigned HALF_DIV = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpol,
  input  logic       cpha,
  input  logic       lsb_first,
  input  logic       irq_en,
  input  logic       sel_req,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       ss_n,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       irq
);
  // named internal events
  logic      accept;
  logic      run;
  logic      tick;
  logic      phase;
  logic      sample_stb;
  logic      shift_stb;
  logic      fin_stb;
  logic      irq_pend;
  spi_mode_t mode_q;

  assign accept = start && !busy && !ss_n;
  assign sclk   = (busy ? mode_q.cpol : cpol) ^ phase;
  assign irq    = irq_pend && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_n     <= 1'b1;
      mode_q   <= '0;
      done     <= 1'b0;
      irq_pend <= 1'b0;
    end else begin
      ss_n <= ~sel_req;
      done <= fin_stb;
      if (accept) begin
        mode_q   <= '{cpol: cpol, cpha: cpha, lsb_first: lsb_first};
        irq_pend <= 1'b0;
      end else if (fin_stb) begin
        irq_pend <= 1'b1;
      end
    end
  end

  spi_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (tick)
  );

  spi_edge_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .tick      (tick),
    .cpha      (mode_q.cpha),
    .run       (run),
    .busy      (busy),
    .phase     (phase),
    .sample_stb(sample_stb),
    .shift_stb (shift_stb),
    .fin_stb   (fin_stb)
  );

  spi_shift_path u_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .tx_byte   (tx_byte),
    .lsb       (accept ? lsb_first : mode_q.lsb_first),
    .miso      (miso),
    .sample_stb(sample_stb),
    .shift_stb (shift_stb),
    .fin_stb   (fin_stb),
    .mosi      (mosi),
    .rx_byte   (rx_byte)
  );
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpol,
  input logic       start,
  input logic       ss_n,
  input logic       sclk,
  input logic       busy,
  input logic       done,
  input logic [7:0] rx_byte
);
  logic       sclk_q;
  logic [5:0] edge_cnt;
  logic       sclk_moved;

  assign sclk_moved = (sclk != sclk_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      edge_cnt <= '0;
    end else begin
      sclk_q <= sclk;
      if (start && !busy && !ss_n) edge_cnt <= '0;
      else if (sclk_moved)         edge_cnt <= edge_cnt + 1'b1;
    end
  end

  AST_EDGE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (edge_cnt + 6'(sclk_moved)) == 6'd16); // R1
  AST_SCLK_REST: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk == cpol); // R2
  AST_SS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ss_n && !busy) |=> !busy); // R6
  AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !ss_n && !busy) |=> busy); // R8
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R9
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rx_byte)); // R9
endmodule

bind spi_byte_master spi_byte_master_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cpol   (cpol),
  .start  (start),
  .ss_n   (ss_n),
  .sclk   (sclk),
  .busy   (busy),
  .done   (done),
  .rx_byte(rx_byte)
);

// File: tb/spi_byte_master_bench.sv
`timescale 1ns/1ps
module spi_byte_master_bench;
  localparam int H = 3;
  localparam int FIRST_EDGE_N = 2 + H;
  localparam int DONE_N = 2 + 16 * H;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpol = 1'b0, cpha = 1'b0, lsb_first = 1'b0, irq_en = 1'b0;
  logic sel_req = 1'b0, start = 1'b0, miso = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic sclk, mosi, ss_n, busy, done, irq;
  logic [7:0] rx_byte;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  spi_byte_master #(.HALF_DIV(H)) u_spi_byte_master (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha), .lsb_first(lsb_first),
    .irq_en(irq_en), .sel_req(sel_req), .start(start), .tx_byte(tx_byte),
    .miso(miso), .sclk(sclk), .mosi(mosi), .ss_n(ss_n), .busy(busy),
    .done(done), .rx_byte(rx_byte), .irq(irq)
  );

  // behavioural slave
  logic       s_active = 1'b0;
  logic       s_cpha = 1'b0, s_lsb = 1'b0;
  logic [7:0] s_tx = 8'h00, s_rx = 8'h00;
  int         s_edges = 0, s_rxi = 0, s_txi = 0;

  function automatic int pos(int i, logic lsb);
    return lsb ? i : 7 - i;
  endfunction

  always @(sclk) begin
    if (s_active) begin
      s_edges = s_edges + 1;
      // edge number s_edges is 1-based; odd numbers are leading edges
      if ((s_edges % 2 == 1) == (s_cpha == 1'b0)) begin
        if (s_rxi < 8) s_rx[pos(s_rxi, s_lsb)] = mosi;
        s_rxi = s_rxi + 1;
      end else if (s_txi < 8) begin
        miso = s_tx[pos(s_txi, s_lsb)];
        s_txi = s_txi + 1;
      end
    end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 150000) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  // {cpol, cpha, lsb_first, tx, slave byte}
  localparam logic [18:0] VEC [8] = '{
    {3'b000, 8'hA5, 8'h3C},
    {3'b001, 8'h81, 8'h7E},
    {3'b010, 8'h1F, 8'hC4},
    {3'b011, 8'h96, 8'h02},
    {3'b100, 8'h40, 8'hF1},
    {3'b101, 8'hE7, 8'h18},
    {3'b110, 8'h0D, 8'hB2},
    {3'b111, 8'h5A, 8'h69}
  };

  int first_n, done_n;

  task automatic run_xfer(input logic p, input logic h, input logic l,
                          input logic [7:0] tx, input logic [7:0] sv,
                          input logic inject, input string tag);
    int n;
    logic [7:0] rx_before;
    @(negedge clk);
    cpol = p; cpha = h; lsb_first = l;
    s_cpha = h; s_lsb = l; s_tx = sv; s_rx = 8'h00;
    s_edges = 0; s_rxi = 0;
    if (!h) begin miso = sv[pos(0, l)]; s_txi = 1; end
    else begin miso = 1'b0; s_txi = 0; end
    @(negedge clk);
    s_active = 1'b1;
    rx_before = rx_byte;
    tx_byte = tx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    check(busy == 1'b1, {tag, " R8 busy after start"}, busy, 1);
    check(rx_byte == rx_before, {tag, " R9 rx held during transfer"}, rx_byte, rx_before);
    first_n = 0; done_n = 0;
    while (n < 2000) begin
      @(negedge clk);
      n = n + 1;
      start = 1'b0;
      if (inject && n == 10) begin start = 1'b1; tx_byte = ~tx; end
      if (first_n == 0 && sclk != p) first_n = n;
      if (done) begin done_n = n; break; end
    end
    s_active = 1'b0;
    check(first_n == FIRST_EDGE_N, {tag, " R8 first edge cycle"}, first_n, FIRST_EDGE_N);
    check(done_n == DONE_N, {tag, " R8 R9 done cycle"}, done_n, DONE_N);
    check(busy == 1'b0, {tag, " R9 busy low with done"}, busy, 0);
    check(s_edges == 16, {tag, " R1 edge count"}, s_edges, 16);
    check(sclk == p, {tag, " R2 clock back at rest"}, sclk, p);
    check(rx_byte == sv, {tag, " R3 R4 R5 received byte"}, rx_byte, sv);
    check(s_rx == tx, {tag, " R3 R4 R5 slave captured byte"}, s_rx, tx);
    @(negedge clk);
    check(done == 1'b0, {tag, " R9 done lasts one cycle"}, done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R2 R6 R9 R10 reset state
    check(sclk == 1'b0, "R2 reset sclk", sclk, 0);
    check(ss_n == 1'b1, "R6 reset ss_n", ss_n, 1);
    check(busy == 1'b0, "R8 reset busy", busy, 0);
    check(done == 1'b0, "R9 reset done", done, 0);
    check(rx_byte == 8'h00, "R9 reset rx_byte", rx_byte, 0);
    check(irq == 1'b0, "R10 reset irq", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 start ignored while slave select released
    start = 1'b1; tx_byte = 8'hFF;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b0, "R6 start ignored with ss_n high", busy, 0);
    repeat (2 * H + 2) @(negedge clk);
    check(busy == 1'b0 && sclk == 1'b0, "R6 no transfer ran", {busy, sclk}, 0);

    // R2 rest level follows polarity
    cpol = 1'b1;
    @(negedge clk);
    check(sclk == 1'b1, "R2 rest high with cpol 1", sclk, 1);
    cpol = 1'b0;

    // R6 slave select follows host request
    sel_req = 1'b1;
    @(negedge clk);
    check(ss_n == 1'b0, "R6 ss_n asserted", ss_n, 0);

    irq_en = 1'b1;
    for (int i = 0; i < 8; i++) begin
      run_xfer(VEC[i][18], VEC[i][17], VEC[i][16], VEC[i][15:8], VEC[i][7:0],
               1'b0, $sformatf("vec%0d", i));
      check(irq == 1'b1, $sformatf("vec%0d R10 irq after done", i), irq, 1);
    end

    // R10 masking and clearing
    irq_en = 1'b0;
    @(negedge clk);
    check(irq == 1'b0, "R10 irq masked", irq, 0);
    irq_en = 1'b1;
    @(negedge clk);
    check(irq == 1'b1, "R10 pending held while masked", irq, 1);
    @(negedge clk);
    tx_byte = 8'h33; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(irq == 1'b0, "R10 irq cleared by accepted start", irq, 0);
    while (!done) @(negedge clk);
    repeat (2) @(negedge clk);

    // R7 start during a running transfer
    run_xfer(1'b0, 1'b0, 1'b0, 8'hC3, 8'h5E, 1'b1, "inject");
    check(busy == 1'b0, "R7 injected start did not begin a transfer", busy, 0);

    // R9 received byte held after release
    sel_req = 1'b0;
    repeat (5) @(negedge clk);
    check(rx_byte == 8'h5E, "R9 rx_byte stable after completion", rx_byte, 8'h5E);
    check(ss_n == 1'b1, "R6 ss_n released", ss_n, 1);

    finish_run();
  end
endmodule